// File: doc/BRIEF.md
# Audio DMA Request Steering Controller

This block sits between the sample FIFOs of a stereo audio codec and the system DMA controller. It owns the transfer-configuration register and a small pin-control register. From them it decides, for each direction, whether a FIFO "data ready" strobe turns into a DMA request or is left to programmed I/O. It can also fold both directions onto one request line, so that a system with a single DMA channel can still move audio.

Besides request steering, the block does three more things:
- It produces a one-cycle autocalibration start pulse when the mode-change-enable bit is released.
- It raises an interrupt when the sample counter reaches its terminal count. The interrupt is held until software clears it.
- It holds an INIT status flag high for a fixed interval after every sample-rate change. A cycle counter, sized from the clock frequency parameter, measures that interval.

Software reaches all of this through an indexed register port. Writes are synchronous and reads are combinational on the index.

Top module: `audio_dma_steer`

## Requirements
- R1: After reset, index 9 reads 0x08 and index 10 reads 0x00. `playReq`, `capReq`, `irqOut`, `initFlag` and `calStart` are all low.
- R2: Index 9 bit layout:
  - bit 0: playback enable
  - bit 1: capture enable
  - bit 2: single-channel mode
  - bit 3: calibrate-on-release
  - bit 6: playback PIO select
  - bit 7: capture PIO select

  Bits 4 and 5 read back as 0 whatever was written.
- R3: With playback enabled and playback PIO clear, `playReq` goes high in the cycle after a `playReady` strobe is sampled. It stays high until `playAck` is sampled high and drops in the next cycle. It rises again only on a new strobe.
- R4: When a direction's PIO select bit is 1, that direction's ready strobes never raise a request line.
- R5: With single-channel mode clear, capture requests behave as in R3 on `capReq`, using `capReady` and `capAck`.
- R6: With single-channel mode set, capture requests appear on `playReq` and are cleared by `playAck`. `capReq` stays low and `capAck` has no effect.
- R7: With single-channel mode set and both enables set, capture strobes raise no request, while playback is still serviced.
- R8: When calibrate-on-release is 1, sampling `mceBit` low after it was sampled high gives a `calStart` pulse of exactly one cycle in the following cycle. When the bit is 0, no pulse occurs.
- R9: A write to the enable bits of index 9 changes request gating in the cycle after the write, with `mceBit` held low.
- R10: Index 10 holds interrupt enable in bit 1 and init-disable in bit 0, and its other bits read 0.
  - With interrupt enable set, a `termCount` pulse drives `irqOut` high in the next cycle.
  - `irqOut` stays high until any write to index 11, which reads `irqOut` in bit 0.
  - With interrupt enable clear, `termCount` is ignored.
- R11: Unless init-disable is set, a `rateChange` strobe drives `initFlag` high for exactly (CLK_HZ/1e6)·INIT_US cycles, starting in the next cycle. With init-disable set, the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register index |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| mceBit | input | 1 | Mode-change-enable level |
| playReady | input | 1 | Playback FIFO wants a sample (strobe) |
| capReady | input | 1 | Capture FIFO has a sample (strobe) |
| playAck | input | 1 | DMA acknowledge on the playback channel |
| capAck | input | 1 | DMA acknowledge on the capture channel |
| rateChange | input | 1 | Sample-rate change strobe |
| termCount | input | 1 | Sample counter terminal-count pulse |
| playReq | output | 1 | Playback (or shared) DMA request |
| capReq | output | 1 | Capture DMA request |
| irqOut | output | 1 | Interrupt pin |
| initFlag | output | 1 | INIT status flag |
| calStart | output | 1 | Autocalibration start pulse |

## Verification
Each result has a fixed latency:
- Request lines, the interrupt, the calibration pulse and the INIT flag are registered, so each answers one clock edge after the strobe, acknowledge or level change that caused it.
- Configuration gating of the requests and the read port act in the cycle right after a write edge.

The driver drives inputs just after the falling edge and queues each expectation for the next falling edge. The monitor compares one time unit after that falling edge, so every comparison falls exactly one rising edge after its stimulus. The INIT window is checked on every cycle of its length and on the first cycle after it.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

  localparam int REG_W = 8;

  // configuration register bit positions (software-visible layout)
  localparam int B_PLAY_EN  = 0;
  localparam int B_CAP_EN   = 1;
  localparam int B_SINGLE   = 2;
  localparam int B_CAL_EN   = 3;
  localparam int B_PLAY_PIO = 6;
  localparam int B_CAP_PIO  = 7;

  localparam logic [REG_W-1:0] CFG_RESET = 8'h08;
  localparam logic [REG_W-1:0] CFG_WMASK = 8'hCF;

  // pin-control register bit positions
  localparam int B_INIT_DIS = 0;
  localparam int B_IRQ_EN   = 1;

  localparam int NUM_DIR = 2;
  localparam int DIR_PLAY = 0;
  localparam int DIR_CAP  = 1;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic [NUM_DIR-1:0] dmaOn;   // direction is in DMA mode and not suppressed
    logic               single;  // share the playback request line
    logic               irqSet;  // terminal count with interrupt enabled
    logic               irqClr;  // software write to status index
    logic               initLoad;// start the INIT interval
  } ctrlStrb_t;

endpackage

// File: rtl/audio_dma_ctrl.sv
module audio_dma_ctrl
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_IDX  = 9,
  parameter int PIN_IDX  = 10,
  parameter int STAT_IDX = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              mceBit,
  input  logic              rateChange,
  input  logic              termCount,
  input  logic              irqPendIn,
  output logic              calStart,
  output logic [REG_W-1:0]  cfgQ,
  output ctrlStrb_t         strb
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_IDX);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(PIN_IDX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_IDX);

  logic [1:0] pinQ;
  logic       mcePrev;
  logic       wrCfg, wrPin, wrStat;
  logic       bothOn;

  assign wrCfg  = regWr && (regAddr == A_CFG);
  assign wrPin  = regWr && (regAddr == A_PIN);
  assign wrStat = regWr && (regAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= CFG_RESET;
      pinQ    <= '0;
      mcePrev <= 1'b0;
      calStart <= 1'b0;
    end else begin
      if (wrCfg) cfgQ <= regWrData & CFG_WMASK;
      if (wrPin) pinQ <= regWrData[1:0];
      mcePrev  <= mceBit;
      calStart <= mcePrev && !mceBit && cfgQ[B_CAL_EN];
    end
  end

  always_comb begin
    unique case (regAddr)
      A_CFG:   regRdData = cfgQ;
      A_PIN:   regRdData = {{(REG_W-2){1'b0}}, pinQ};
      A_STAT:  regRdData = {{(REG_W-1){1'b0}}, irqPendIn};
      default: regRdData = '0;
    endcase
  end

  assign bothOn = cfgQ[B_PLAY_EN] && cfgQ[B_CAP_EN];

  always_comb begin
    strb.dmaOn[DIR_PLAY] = cfgQ[B_PLAY_EN] && !cfgQ[B_PLAY_PIO];
    strb.dmaOn[DIR_CAP]  = cfgQ[B_CAP_EN] && !cfgQ[B_CAP_PIO]
                           && !(cfgQ[B_SINGLE] && bothOn);
    strb.single   = cfgQ[B_SINGLE];
    strb.irqSet   = termCount && pinQ[B_IRQ_EN];
    strb.irqClr   = wrStat;
    strb.initLoad = rateChange && !pinQ[B_INIT_DIS];
  end

endmodule

// File: rtl/audio_dma_dpath.sv
module audio_dma_dpath
  import audio_dma_pkg::*;
#(
  parameter int INIT_CYCLES = 25000,
  parameter int CNT_W       = 15
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  input  logic      playReady,
  input  logic      capReady,
  input  logic      playAck,
  input  logic      capAck,
  output logic      playReq,
  output logic      capReq,
  output logic      irqOut,
  output logic      initFlag
);

  logic [NUM_DIR-1:0] readyVec, ackVec, pend, live;
  logic [CNT_W-1:0]   initCnt;

  assign readyVec = {capReady, playReady};
  // in shared mode the capture acknowledge arrives on the playback channel
  assign ackVec   = {(strb.single ? playAck : capAck), playAck};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    always_ff @(posedge clk) begin
      if (!rstN)                 pend[d] <= 1'b0;
      else if (!strb.dmaOn[d])   pend[d] <= 1'b0;
      else if (readyVec[d])      pend[d] <= 1'b1;
      else if (ackVec[d])        pend[d] <= 1'b0;
    end
    assign live[d] = pend[d] && strb.dmaOn[d];
  end

  assign playReq = live[DIR_PLAY] || (strb.single && live[DIR_CAP]);
  assign capReq  = !strb.single && live[DIR_CAP];

  always_ff @(posedge clk) begin
    if (!rstN)            irqOut <= 1'b0;
    else if (strb.irqSet) irqOut <= 1'b1;
    else if (strb.irqClr) irqOut <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              initCnt <= '0;
    else if (strb.initLoad) initCnt <= CNT_W'(INIT_CYCLES);
    else if (initCnt != '0) initCnt <= initCnt - 1'b1;
  end

  assign initFlag = (initCnt != '0);

endmodule

// File: rtl/audio_dma_steer.sv
module audio_dma_steer
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_IDX  = 9,
  parameter int PIN_IDX  = 10,
  parameter int STAT_IDX = 11,
  parameter int CLK_HZ   = 125_000_000,
  parameter int INIT_US  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              mceBit,
  input  logic              playReady,
  input  logic              capReady,
  input  logic              playAck,
  input  logic              capAck,
  input  logic              rateChange,
  input  logic              termCount,
  output logic              playReq,
  output logic              capReq,
  output logic              irqOut,
  output logic              initFlag,
  output logic              calStart
);

  localparam int INIT_CYCLES = (CLK_HZ / 1_000_000) * INIT_US;
  localparam int CNT_W       = $clog2(INIT_CYCLES + 1);

  ctrlStrb_t       strb;
  logic [REG_W-1:0] cfgQ;

  audio_dma_ctrl #(
    .ADDR_W(ADDR_W), .CFG_IDX(CFG_IDX), .PIN_IDX(PIN_IDX), .STAT_IDX(STAT_IDX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mceBit(mceBit),
    .rateChange(rateChange), .termCount(termCount), .irqPendIn(irqOut),
    .calStart(calStart), .cfgQ(cfgQ), .strb(strb)
  );

  audio_dma_dpath #(
    .INIT_CYCLES(INIT_CYCLES), .CNT_W(CNT_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .playReady(playReady), .capReady(capReady),
    .playAck(playAck), .capAck(capAck),
    .playReq(playReq), .capReq(capReq),
    .irqOut(irqOut), .initFlag(initFlag)
  );

endmodule

// File: rtl/audio_dma_steer_chk.sv
module audio_dma_steer_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] cfgQ,
  input logic       mceBit,
  input logic       playReq,
  input logic       capReq,
  input logic       irqOut,
  input logic       termCount,
  input logic       initFlag,
  input logic       rateChange,
  input logic       calStart
);

  // R6
  single_cap_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[2] |-> !capReq);

  // R4
  play_req_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    playReq |-> ((cfgQ[0] && !cfgQ[6]) || (cfgQ[2] && cfgQ[1] && !cfgQ[7])));

  // R8
  cal_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> (!$past(mceBit) && $past(cfgQ[3])));

  // R8
  cal_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    calStart |=> !calStart);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(termCount));

  // R11
  init_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initFlag) |-> $past(rateChange));

endmodule

bind audio_dma_steer audio_dma_steer_chk i_chk (
  .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .mceBit(mceBit),
  .playReq(playReq), .capReq(capReq), .irqOut(irqOut),
  .termCount(termCount), .initFlag(initFlag), .rateChange(rateChange),
  .calStart(calStart)
);

// File: tb/test_audio_dma_steer.sv
module test_audio_dma_steer;

  localparam int INIT_LEN = 20; // 1 MHz * 20 us

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic mceBit = 0, playReady = 0, capReady = 0, playAck = 0, capAck = 0;
  logic rateChange = 0, termCount = 0;
  logic playReq, capReq, irqOut, initFlag, calStart;

  always #4 clk = ~clk;

  audio_dma_steer #(.CLK_HZ(1_000_000), .INIT_US(INIT_LEN)) i_audio_dma_steer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mceBit(mceBit),
    .playReady(playReady), .capReady(capReady), .playAck(playAck),
    .capAck(capAck), .rateChange(rateChange), .termCount(termCount),
    .playReq(playReq), .capReq(capReq), .irqOut(irqOut),
    .initFlag(initFlag), .calStart(calStart)
  );

  typedef enum int {S_PREQ, S_CREQ, S_IRQ, S_INIT, S_CAL, S_RD} sel_t;
  typedef struct {
    sel_t       sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sbQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  function automatic logic [7:0] observe(sel_t s);
    case (s)
      S_PREQ:  return {7'b0, playReq};
      S_CREQ:  return {7'b0, capReq};
      S_IRQ:   return {7'b0, irqOut};
      S_INIT:  return {7'b0, initFlag};
      S_CAL:   return {7'b0, calStart};
      default: return regRdData;
    endcase
  endfunction

  // monitor: compares queued expectations one rising edge after they were queued
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sbQ.pop_front();
        act = observe(it.sel);
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s %s actual=%0h expected=%0h", it.req, it.sel.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(sel_t s, logic [7:0] v, string r);
    item_t it;
    it.sel = s; it.exp = v; it.req = r;
    sbQ.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rstN = 1'b1;

    // R1 reset state
    regAddr = 4'd9;
    expect_v(S_RD, 8'h08, "R1"); expect_v(S_PREQ, 0, "R1"); expect_v(S_CREQ, 0, "R1");
    expect_v(S_IRQ, 0, "R1"); expect_v(S_INIT, 0, "R1"); expect_v(S_CAL, 0, "R1");
    tick();
    regAddr = 4'd10; expect_v(S_RD, 8'h00, "R1"); tick();

    // R2 layout and reserved bits
    wr(4'd9, 8'hFF);
    regAddr = 4'd9; expect_v(S_RD, 8'hCF, "R2"); tick();
    wr(4'd9, 8'h30);
    regAddr = 4'd9; expect_v(S_RD, 8'h00, "R2"); tick();

    // R3 playback request handshake
    wr(4'd9, 8'h01);
    playReady = 1; expect_v(S_PREQ, 1, "R3"); expect_v(S_CREQ, 0, "R3"); tick(); playReady = 0;
    expect_v(S_PREQ, 1, "R3"); tick();
    playAck = 1; expect_v(S_PREQ, 0, "R3"); tick(); playAck = 0;
    expect_v(S_PREQ, 0, "R3"); tick();

    // R4 PIO select suppresses requests
    wr(4'd9, 8'h41);
    playReady = 1; expect_v(S_PREQ, 0, "R4"); tick(); playReady = 0;
    expect_v(S_PREQ, 0, "R4"); tick();
    wr(4'd9, 8'h82);
    capReady = 1; expect_v(S_CREQ, 0, "R4"); expect_v(S_PREQ, 0, "R4"); tick(); capReady = 0;

    // R5 capture request in dual mode
    wr(4'd9, 8'h02);
    capReady = 1; expect_v(S_CREQ, 1, "R5"); expect_v(S_PREQ, 0, "R5"); tick(); capReady = 0;
    playAck = 1; expect_v(S_CREQ, 1, "R5"); tick(); playAck = 0;
    capAck = 1; expect_v(S_CREQ, 0, "R5"); tick(); capAck = 0;

    // R9 enable change acts without mode-change-enable
    wr(4'd9, 8'h01);
    playReady = 1; expect_v(S_PREQ, 1, "R9"); tick(); playReady = 0;
    wr(4'd9, 8'h00);
    expect_v(S_PREQ, 0, "R9"); tick();

    // R6 single-channel steering
    wr(4'd9, 8'h06);
    capReady = 1; expect_v(S_PREQ, 1, "R6"); expect_v(S_CREQ, 0, "R6"); tick(); capReady = 0;
    capAck = 1; expect_v(S_PREQ, 1, "R6"); expect_v(S_CREQ, 0, "R6"); tick(); capAck = 0;
    playAck = 1; expect_v(S_PREQ, 0, "R6"); tick(); playAck = 0;

    // R7 single-channel with both enabled: playback wins
    wr(4'd9, 8'h07);
    capReady = 1; expect_v(S_PREQ, 0, "R7"); expect_v(S_CREQ, 0, "R7"); tick(); capReady = 0;
    playReady = 1; expect_v(S_PREQ, 1, "R7"); tick(); playReady = 0;
    playAck = 1; expect_v(S_PREQ, 0, "R7"); tick(); playAck = 0;

    // R8 calibration pulse on release
    wr(4'd9, 8'h08);
    mceBit = 1; expect_v(S_CAL, 0, "R8"); tick();
    mceBit = 0; expect_v(S_CAL, 1, "R8"); tick();
    expect_v(S_CAL, 0, "R8"); tick();
    wr(4'd9, 8'h00);
    mceBit = 1; tick();
    mceBit = 0; expect_v(S_CAL, 0, "R8"); tick();
    expect_v(S_CAL, 0, "R8"); tick();

    // R10 interrupt enable, hold and clear
    wr(4'd10, 8'hFE);
    regAddr = 4'd10; expect_v(S_RD, 8'h02, "R10"); tick();
    termCount = 1; expect_v(S_IRQ, 1, "R10"); tick(); termCount = 0;
    expect_v(S_IRQ, 1, "R10"); regAddr = 4'd11; expect_v(S_RD, 8'h01, "R10"); tick();
    wr(4'd11, 8'h00);
    expect_v(S_IRQ, 0, "R10"); tick();
    wr(4'd10, 8'h00);
    termCount = 1; expect_v(S_IRQ, 0, "R10"); tick(); termCount = 0;
    expect_v(S_IRQ, 0, "R10"); tick();

    // R11 INIT window length
    rateChange = 1; expect_v(S_INIT, 1, "R11"); tick(); rateChange = 0;
    for (int i = 1; i < INIT_LEN; i++) begin
      expect_v(S_INIT, 1, "R11"); tick();
    end
    expect_v(S_INIT, 0, "R11"); tick();
    wr(4'd10, 8'h01);
    rateChange = 1; expect_v(S_INIT, 0, "R11"); tick(); rateChange = 0;
    expect_v(S_INIT, 0, "R11"); tick();

    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule